// File: doc/BRIEF.md
# RAM Controller Status and Interrupt Register Block

This block is the 32-bit register file that sits beside an on-chip RAM controller. It takes single-cycle APB-style accesses (setup phase, then an access phase in which the transfer completes with no wait states). It decides whether the access hits a register and applies that register's access rule. It also drives one level-sensitive interrupt line.

The interrupt path has three parts. A status register has eleven bits. Error-detection logic elsewhere raises these bits through an event input, and software clears them by writing ones. A mask register is read-only from the bus. Its bits change only through two command offsets: one that clears mask bits (unmask) and one that sets them (mask). Neither command offset stores what is written.

The remaining registers have three kinds of access:
- ECC control, error control, scrub-clear and fault-injection values are plain read/write storage for the controller.
- Three first-failure records are loaded by hardware strobes and cannot be written from the bus: correctable, uncorrectable, and the read-modify-write address.
- An implementation register reports the RAM size as a code computed from a parameter, and a power-ready debug register holds a fixed value. Both are read-only.

Top module: `ramctl_csr`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the registers read as follows: status (0x00) is 0, mask (0x04) is 0x7FF, error control (0x10) is 0xF and power-ready debug (0x84) is 0xFFFF. irq_o is low.
- R2: A 1 on evt_i[b] at a clock edge sets status bit b. Writing to offset 0x00 clears each status bit written as 1 and leaves the others unchanged. When an event and a clear hit the same bit at the same edge, the bit stays set.
- R3: Bus writes to the mask register (0x04) have no effect on it.
- R4: A write to offset 0x08 clears every mask bit written as 1. A write to offset 0x0C sets every mask bit written as 1. Both offsets read back as 0.
- R5: irq_o is high exactly when some status bit is set while its mask bit is clear. It follows the registered status and mask with no further delay.
- R6: The implementation register (0x80) reports the RAM size in bits [3:0]. The codes are 64 KiB=0, 128 KiB=1, 256 KiB=2, 512 KiB=3 and 1 MiB=4, and any other size reads as 0xF. The default size is 1 MiB.
- R7: Writable fields keep only their active bits and read zero above them. Error control (0x10) is 4 bits, ECC control (0x14) 3 bits, scrub-clear (0x18) 8 bits, fault-injection count (0x1C) 24 bits, fault-injection data words (0x20..0x2C) 32 bits and fault-injection syndrome (0x30) 16 bits.
- R8: The first-failure records load on their strobes. The correctable record is at 0x40, with its address, then data words 0 to 3, then its syndrome. The uncorrectable record is at 0x60 in the same layout. The read-modify-write address is at 0x78. Addresses are 20 bits and syndromes 16 bits. Bus writes to these registers are ignored.
- R9: An access phase to an unmapped offset, or to an address with paddr[1:0] not 0, asserts pslverr. Such a read returns 0 and such a write changes nothing.
- R10: Bus writes to the implementation (0x80) and power-ready debug (0x84) registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Error response for unmapped or misaligned access |
| evt_i | input | 11 | Status set pulses, one per source |
| ce_stb_i | input | 1 | Load the correctable first-failure record |
| ue_stb_i | input | 1 | Load the uncorrectable first-failure record |
| rmw_stb_i | input | 1 | Load the read-modify-write failure address |
| cap_addr_i | input | 20 | Captured failing address |
| cap_data_i | input | 128 | Captured failing data, word 0 in bits [31:0] |
| cap_syn_i | input | 16 | Captured syndrome |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench aims at the edge where an event and a write-one-to-clear land on the same status bit. A design that gave priority to the clear would drop that event and lower the interrupt. It also checks that the mask moves only through the two command offsets and that those offsets read as zero: a design that stored the written value, or decoded the mask offset as writable, would return the wrong mask or raise the interrupt when it should not. The remaining checks target reserved-bit truncation, bus writes to the capture and read-only registers, and misaligned or unmapped accesses. A faulty decoder would alias these onto a neighbouring register or fail to flag the error.

// File: rtl/ramctl_csr_pkg.sv
// Package: offsets, field widths and the capture record type shared by the
// RAM controller register block. Offsets are byte addresses, word aligned.
package ramctl_csr_pkg;

    localparam int N_SRC   = 11;
    localparam int DW      = 32;
    localparam int FA_W    = 20;
    localparam int SYN_W   = 16;
    localparam int N_WORDS = 4;
    localparam int FD_W    = DW * N_WORDS;

    localparam int ERRC_W  = 4;
    localparam int ECC_W   = 3;
    localparam int SCRB_W  = 8;
    localparam int FICNT_W = 24;
    localparam int PDBG_W  = 16;

    localparam logic [11:0] OFF_STAT    = 12'h000;
    localparam logic [11:0] OFF_MASK    = 12'h004;
    localparam logic [11:0] OFF_UNMASK  = 12'h008;
    localparam logic [11:0] OFF_MASKSET = 12'h00C;
    localparam logic [11:0] OFF_ERRCTL  = 12'h010;
    localparam logic [11:0] OFF_ECCCFG  = 12'h014;
    localparam logic [11:0] OFF_SCRUB   = 12'h018;
    localparam logic [11:0] OFF_FICNT   = 12'h01C;
    localparam logic [11:0] OFF_FID     = 12'h020;
    localparam logic [11:0] OFF_FISYN   = 12'h030;
    localparam logic [11:0] OFF_CE      = 12'h040;
    localparam logic [11:0] OFF_UE      = 12'h060;
    localparam logic [11:0] OFF_RMW     = 12'h078;
    localparam logic [11:0] OFF_IMPL    = 12'h080;
    localparam logic [11:0] OFF_PWRDBG  = 12'h084;

    typedef struct packed {
        logic [FA_W-1:0]  addr;
        logic [FD_W-1:0]  data;
        logic [SYN_W-1:0] syn;
    } ffail_rec_t;

    // Encode a RAM size in bytes; unsupported sizes map to 0xF.
    function automatic logic [3:0] size_code(longint unsigned bytes);
        case (bytes)
            64'd65536:   return 4'd0;
            64'd131072:  return 4'd1;
            64'd262144:  return 4'd2;
            64'd524288:  return 4'd3;
            64'd1048576: return 4'd4;
            default:     return 4'hF;
        endcase
    endfunction

endpackage

// File: rtl/ramctl_irq_ctrl.sv
// Interrupt status and mask for the RAM controller register block.
// Assumes the write strobes are one-hot (distinct offsets) and already
// qualified by the bus decode. Status is sticky until cleared by a
// write-one; events win over a same-cycle clear. The mask only moves
// through the unmask/maskset command strobes.
module ramctl_irq_ctrl #(
    parameter int NS = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] evt_i,
    input  logic          clr_we,
    input  logic          unmask_we,
    input  logic          maskset_we,
    input  logic [NS-1:0] wdata_i,
    output logic [NS-1:0] stat_o,
    output logic [NS-1:0] mask_o,
    output logic          irq_o
);

    logic [NS-1:0] stat_q;
    logic [NS-1:0] mask_q;
    logic [NS-1:0] clr_bits;

    // Bits to clear this cycle from a status write.
    always_comb clr_bits = clr_we ? wdata_i : '0;

    // Status register: clear first, then events set (event priority).
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_bits) | evt_i;
    end

    // Mask register: all sources masked at reset, moved only by commands.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= '1;
        else if (unmask_we)  mask_q <= mask_q & ~wdata_i;
        else if (maskset_we) mask_q <= mask_q | wdata_i;
    end

    // Level interrupt from any unmasked pending source.
    always_comb irq_o = |(stat_q & ~mask_q);

    assign stat_o = stat_q;
    assign mask_o = mask_q;

    // An event seen at an edge is set in status after that edge.
    assert_evt_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    // Without a command strobe the mask does not move.
    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(unmask_we || maskset_we) |=> $stable(mask_q));

    // The interrupt can only rise after an event or an unmask command.
    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((|evt_i) || unmask_we));

endmodule

// File: rtl/ramctl_ffail_bank.sv
// One first-failure capture record. Loads address (and, when HAS_DATA,
// data and syndrome) on a hardware strobe; it has no bus write path.
module ramctl_ffail_bank
    import ramctl_csr_pkg::*;
#(
    parameter bit HAS_DATA = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_i,
    input  ffail_rec_t rec_i,
    output ffail_rec_t rec_o
);

    ffail_rec_t rec_q;

    // Capture the record on the strobe; unused fields stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else if (stb_i) begin
            rec_q.addr <= rec_i.addr;
            if (HAS_DATA) begin
                rec_q.data <= rec_i.data;
                rec_q.syn  <= rec_i.syn;
            end
        end
    end

    assign rec_o = rec_q;

    // Record is held whenever the strobe is idle.
    assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(rec_q));

endmodule

// File: rtl/ramctl_csr.sv
// Register block for an on-chip RAM controller. Decodes zero-wait APB-style
// accesses, applies per-register access rules, hosts plain storage for
// ECC/fault-injection controls, exposes three hardware-loaded failure
// records and a level interrupt. Assumes one access per setup/access pair.
module ramctl_csr
    import ramctl_csr_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter longint unsigned RAM_BYTES = 64'd1048576
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DW-1:0]     pwdata,
    output logic [DW-1:0]     prdata,
    output logic              pslverr,
    input  logic [N_SRC-1:0]  evt_i,
    input  logic              ce_stb_i,
    input  logic              ue_stb_i,
    input  logic              rmw_stb_i,
    input  logic [FA_W-1:0]   cap_addr_i,
    input  logic [FD_W-1:0]   cap_data_i,
    input  logic [SYN_W-1:0]  cap_syn_i,
    output logic              irq_o
);

    localparam logic [3:0] SIZE_CODE = size_code(RAM_BYTES);
    localparam int         N_BANK    = 3;

    logic [11:0]       off;
    logic              access, aligned, hit, wr;
    logic [DW-1:0]     rd_data;
    logic [N_SRC-1:0]  stat, mask;

    logic [ERRC_W-1:0]  errctl_q;
    logic [ECC_W-1:0]   ecc_q;
    logic [SCRB_W-1:0]  scrub_q;
    logic [FICNT_W-1:0] ficnt_q;
    logic [DW-1:0]      fid_q [N_WORDS];
    logic [SYN_W-1:0]   fisyn_q;

    ffail_rec_t cap_in;
    ffail_rec_t rec [N_BANK];
    logic [N_BANK-1:0] stb;

    // Bus phase decode.
    always_comb begin
        off     = 12'(paddr);
        access  = psel && penable;
        aligned = (paddr[1:0] == 2'b00);
    end

    // Register read mux and hit detection; reserved bits zero-extended.
    always_comb begin
        rd_data = '0;
        hit     = aligned;
        case (off)
            OFF_STAT:          rd_data = DW'(stat);
            OFF_MASK:          rd_data = DW'(mask);
            OFF_UNMASK:        rd_data = '0;
            OFF_MASKSET:       rd_data = '0;
            OFF_ERRCTL:        rd_data = DW'(errctl_q);
            OFF_ECCCFG:        rd_data = DW'(ecc_q);
            OFF_SCRUB:         rd_data = DW'(scrub_q);
            OFF_FICNT:         rd_data = DW'(ficnt_q);
            OFF_FID:           rd_data = fid_q[0];
            OFF_FID + 12'h4:   rd_data = fid_q[1];
            OFF_FID + 12'h8:   rd_data = fid_q[2];
            OFF_FID + 12'hC:   rd_data = fid_q[3];
            OFF_FISYN:         rd_data = DW'(fisyn_q);
            OFF_CE:            rd_data = DW'(rec[0].addr);
            OFF_CE + 12'h04:   rd_data = rec[0].data[0*DW +: DW];
            OFF_CE + 12'h08:   rd_data = rec[0].data[1*DW +: DW];
            OFF_CE + 12'h0C:   rd_data = rec[0].data[2*DW +: DW];
            OFF_CE + 12'h10:   rd_data = rec[0].data[3*DW +: DW];
            OFF_CE + 12'h14:   rd_data = DW'(rec[0].syn);
            OFF_UE:            rd_data = DW'(rec[1].addr);
            OFF_UE + 12'h04:   rd_data = rec[1].data[0*DW +: DW];
            OFF_UE + 12'h08:   rd_data = rec[1].data[1*DW +: DW];
            OFF_UE + 12'h0C:   rd_data = rec[1].data[2*DW +: DW];
            OFF_UE + 12'h10:   rd_data = rec[1].data[3*DW +: DW];
            OFF_UE + 12'h14:   rd_data = DW'(rec[1].syn);
            OFF_RMW:           rd_data = DW'(rec[2].addr);
            OFF_IMPL:          rd_data = DW'(SIZE_CODE);
            OFF_PWRDBG:        rd_data = DW'({PDBG_W{1'b1}});
            default:           hit = 1'b0;
        endcase
        if (!hit) rd_data = '0;
    end

    // Response outputs and qualified write strobe.
    always_comb begin
        prdata  = rd_data;
        pslverr = access && !hit;
        wr      = access && pwrite && hit;
    end

    // Plain storage registers; read-only offsets fall through untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            errctl_q <= '1;
            ecc_q    <= '0;
            scrub_q  <= '0;
            ficnt_q  <= '0;
            fisyn_q  <= '0;
            for (int k = 0; k < N_WORDS; k++) fid_q[k] <= '0;
        end else if (wr) begin
            case (off)
                OFF_ERRCTL: errctl_q <= pwdata[ERRC_W-1:0];
                OFF_ECCCFG: ecc_q    <= pwdata[ECC_W-1:0];
                OFF_SCRUB:  scrub_q  <= pwdata[SCRB_W-1:0];
                OFF_FICNT:  ficnt_q  <= pwdata[FICNT_W-1:0];
                OFF_FISYN:  fisyn_q  <= pwdata[SYN_W-1:0];
                default: begin
                    for (int k = 0; k < N_WORDS; k++)
                        if (off == OFF_FID + 12'(4 * k)) fid_q[k] <= pwdata;
                end
            endcase
        end
    end

    ramctl_irq_ctrl #(.NS(N_SRC)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_we     (wr && off == OFF_STAT),
        .unmask_we  (wr && off == OFF_UNMASK),
        .maskset_we (wr && off == OFF_MASKSET),
        .wdata_i    (pwdata[N_SRC-1:0]),
        .stat_o     (stat),
        .mask_o     (mask),
        .irq_o      (irq_o)
    );

    // Shared capture bus and per-record strobes.
    always_comb begin
        cap_in = '{addr: cap_addr_i, data: cap_data_i, syn: cap_syn_i};
        stb    = {rmw_stb_i, ue_stb_i, ce_stb_i};
    end

    // Failure records: index 2 (read-modify-write) keeps only the address.
    for (genvar g = 0; g < N_BANK; g++) begin : g_bank
        ramctl_ffail_bank #(.HAS_DATA(g < 2)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .stb_i (stb[g]),
            .rec_i (cap_in),
            .rec_o (rec[g])
        );
    end

    // An erroring write leaves the storage untouched.
    assert_err_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (access && pwrite && pslverr) |=> ($stable(errctl_q) && $stable(ficnt_q)));

endmodule

// File: tb/test_ramctl_csr.sv
// Directed bench for ramctl_csr: one task per scenario.
module test_ramctl_csr;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0]  paddr = '0;
    logic [31:0]  pwdata = '0;
    logic [31:0]  prdata;
    logic         pslverr;
    logic [10:0]  evt = '0;
    logic         ce_stb = 1'b0, ue_stb = 1'b0, rmw_stb = 1'b0;
    logic [19:0]  cap_addr = '0;
    logic [127:0] cap_data = '0;
    logic [15:0]  cap_syn = '0;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ramctl_csr i_ramctl_csr (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pslverr(pslverr), .evt_i(evt), .ce_stb_i(ce_stb), .ue_stb_i(ue_stb),
        .rmw_stb_i(rmw_stb), .cap_addr_i(cap_addr), .cap_data_i(cap_data),
        .cap_syn_i(cap_syn), .irq_o(irq)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Write; optional event pulse lands on the same edge as the write.
    task automatic apb_wr(logic [11:0] a, logic [31:0] d, logic [10:0] ev,
                          output logic err);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1; evt = ev;
        #1 err = pslverr;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; evt = '0;
    endtask

    task automatic apb_rd(logic [11:0] a, output logic [31:0] d, output logic err);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 d = prdata; err = pslverr;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        logic e;
        apb_wr(a, d, '0, e);
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
        logic [31:0] d; logic e;
        apb_rd(a, d, e);
        chk(tag, d, exp);
    endtask

    task automatic pulse_evt(logic [10:0] v);
        @(negedge clk); evt = v;
        @(negedge clk); evt = '0;
    endtask

    task automatic t_reset;
        chk("R1 irq after reset", 32'(irq), 0);
        rd_chk("R1 status reset", 12'h000, 32'h0);
        rd_chk("R1 mask reset", 12'h004, 32'h7FF);
        rd_chk("R1 errctl reset", 12'h010, 32'hF);
        rd_chk("R1 pwrdbg reset", 12'h084, 32'hFFFF);
        rd_chk("R6 size code 1MiB", 12'h080, 32'h4);
    endtask

    task automatic t_status;
        pulse_evt(11'h405);
        rd_chk("R2 events set status", 12'h000, 32'h405);
        chk("R5 masked sources quiet", 32'(irq), 0);
        wr(12'h000, 32'h0000_0004);
        rd_chk("R2 w1c clears only written ones", 12'h000, 32'h401);
    endtask

    task automatic t_mask;
        wr(12'h004, 32'h0);
        rd_chk("R3 mask write ignored", 12'h004, 32'h7FF);
        chk("R3 irq stays low", 32'(irq), 0);
        wr(12'h008, 32'h1);
        rd_chk("R4 unmask clears bit", 12'h004, 32'h7FE);
        chk("R5 irq on unmasked pending", 32'(irq), 1);
        rd_chk("R4 unmask reads zero", 12'h008, 32'h0);
        wr(12'h00C, 32'h1);
        rd_chk("R4 maskset sets bit", 12'h004, 32'h7FF);
        chk("R5 irq drops when masked", 32'(irq), 0);
        rd_chk("R4 maskset reads zero", 12'h00C, 32'h0);
    endtask

    task automatic t_race;
        logic e;
        wr(12'h008, 32'h1);
        apb_wr(12'h000, 32'h1, 11'h001, e);
        rd_chk("R2 event beats same-cycle clear", 12'h000, 32'h401);
        chk("R5 irq held by surviving event", 32'(irq), 1);
        wr(12'h000, 32'h7FF);
        rd_chk("R2 clear all", 12'h000, 32'h0);
        chk("R5 irq low after clear", 32'(irq), 0);
    endtask

    task automatic t_storage;
        wr(12'h010, 32'hFFFF_FFF0);
        rd_chk("R7 errctl width", 12'h010, 32'h0);
        wr(12'h010, 32'hFFFF_FFFF);
        rd_chk("R7 errctl width ones", 12'h010, 32'hF);
        wr(12'h014, 32'hFFFF_FFFF);
        rd_chk("R7 ecc width", 12'h014, 32'h7);
        wr(12'h018, 32'hFFFF_FFFF);
        rd_chk("R7 scrub width", 12'h018, 32'hFF);
        wr(12'h01C, 32'hFFFF_FFFF);
        rd_chk("R7 ficnt width", 12'h01C, 32'h00FF_FFFF);
        wr(12'h028, 32'hA5C3_0F96);
        rd_chk("R7 fi data word2", 12'h028, 32'hA5C3_0F96);
        rd_chk("R7 fi data word1 untouched", 12'h024, 32'h0);
        wr(12'h030, 32'hFFFF_FFFF);
        rd_chk("R7 fi syndrome width", 12'h030, 32'hFFFF);
        wr(12'h080, 32'h0);
        rd_chk("R10 impl read-only", 12'h080, 32'h4);
        wr(12'h084, 32'h0);
        rd_chk("R10 pwrdbg read-only", 12'h084, 32'hFFFF);
    endtask

    task automatic t_capture;
        @(negedge clk);
        cap_addr = 20'hABCDE; cap_syn = 16'h1234;
        cap_data = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
        ce_stb = 1;
        @(negedge clk); ce_stb = 0;
        cap_addr = 20'h00F0F; cap_syn = 16'hBEEF; cap_data = '1;
        rd_chk("R8 ce addr", 12'h040, 32'hABCDE);
        rd_chk("R8 ce data word1", 12'h048, 32'h2222_2222);
        rd_chk("R8 ce data word3", 12'h050, 32'h4444_4444);
        rd_chk("R8 ce syndrome", 12'h054, 32'h1234);
        wr(12'h040, 32'h0);
        rd_chk("R8 ce addr bus write ignored", 12'h040, 32'hABCDE);
        @(negedge clk); ue_stb = 1; rmw_stb = 1;
        @(negedge clk); ue_stb = 0; rmw_stb = 0;
        rd_chk("R8 ue addr", 12'h060, 32'h00F0F);
        rd_chk("R8 ue syndrome", 12'h074, 32'hBEEF);
        rd_chk("R8 rmw addr", 12'h078, 32'h00F0F);
        rd_chk("R8 ce kept on other strobes", 12'h054, 32'h1234);
    endtask

    task automatic t_unmapped;
        logic [31:0] d; logic e;
        apb_rd(12'h03C, d, e);
        chk("R9 unmapped read err", 32'(e), 1);
        chk("R9 unmapped read zero", d, 0);
        apb_wr(12'h03C, 32'hFFFF_FFFF, '0, e);
        chk("R9 unmapped write err", 32'(e), 1);
        apb_wr(12'h012, 32'h0, '0, e);
        chk("R9 misaligned write err", 32'(e), 1);
        rd_chk("R9 misaligned write ignored", 12'h010, 32'hF);
        apb_rd(12'h011, d, e);
        chk("R9 misaligned read err", 32'(e), 1);
        chk("R9 misaligned read zero", d, 0);
        apb_rd(12'h010, d, e);
        chk("R9 mapped read no err", 32'(e), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_status();
        t_mask();
        t_race();
        t_storage();
        t_capture();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule